// File: doc/BRIEF.md
# Core Power-Down Sequencer

This block puts a processor core to sleep when software asks it to. Software writes a six-bit power-down field in one access. Three of the bits request a sleep level: one light level and two deep levels. Two more bits choose which interrupts may end the light level. The sixth bit is reserved. After a fixed entry latency the block turns off the core clock enable. For either deep level it also turns off the peripheral clock enable.

In the light level the block watches the interrupt lines. A qualifying interrupt wakes the core. The block then sends a one-cycle resume pulse, and a flag on that pulse says whether the interrupt service routine runs before execution continues. The deep levels ignore every interrupt, and only reset ends them. The clock tree, the interrupt controller and the CPU pipeline sit outside the block and appear only as ports.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After a synchronous reset, the field reads 0, cpu_clk_en and periph_clk_en are 1, and resume and take_isr are 0.
- R2: In the running state, a write stores the field. The field bits are: bit 5 reserved, bit 4 wake on any line, bit 3 wake on enabled lines only, bit 2 deep level 3, bit 1 deep level 2, bit 0 light level. Bit 5 always reads 0.
- R3: A write that sets any of bits 2..0 lowers cpu_clk_en exactly ENTRY_DELAY (default 9) clock edges after the write edge. cpu_clk_en stays 1 until then.
- R4: When several level bits are written together, the deepest one wins (bit 2 over bit 1 over bit 0). A write with bits 2..0 all 0 leaves the core running.
- R5: Writes that arrive while the entry delay runs, or while asleep, are ignored and leave the field unchanged.
- R6: The deep levels ignore all interrupt activity. Only reset returns the block to running.
- R7: periph_clk_en is 0 only in a deep level. In the light level it stays 1.
- R8: In the light level with bit 4 set, any asserted interrupt line wakes the core on the next edge and raises resume for exactly one cycle.
- R9: In the light level with only bit 3 set, only lines whose enable bit is 1 wake the core. With neither bit 3 nor bit 4 set, no interrupt wakes it.
- R10: take_isr is 1 on the resume cycle only when an enabled line is asserted and both gie and nmie are 1. Otherwise it is 0. It is never 1 without resume.
- R11: On wake from the light level, bit 0 of the field clears itself and the other stored bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the power-down field |
| csr_wdata | input | 6 | Field value to write |
| csr_rdata | output | 6 | Stored field value |
| irq_lines | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| gie | input | 1 | Global interrupt enable |
| nmie | input | 1 | Non-maskable interrupt enable |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| resume | output | 1 | One-cycle pulse when the core leaves the light level |
| take_isr | output | 1 | Service routine request, valid while resume is 1 |

## Verification
A wrong sequencer state shows up in the two clock enables. An early or late entry moves the falling edge of cpu_clk_en away from the ninth edge after the write. Landing in the wrong level flips periph_clk_en on that same edge. A bad wake decision shows on the edge right after the interrupt is driven: resume fires when it must not, or stays low when it must fire. A wrong self-clear, or a write that was not ignored, shows on csr_rdata one cycle later.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int FIELD_W   = 6;
  localparam int B_RSVD    = 5;
  localparam int B_WAKEANY = 4;
  localparam int B_WAKEEN  = 3;
  localparam int B_DEEP3   = 2;
  localparam int B_DEEP2   = 1;
  localparam int B_LIGHT   = 0;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_LIGHT = 2'd2,
    ST_DEEP  = 2'd3
  } pd_state_t;
endpackage

// File: rtl/pwrdn_field_reg.sv
module pwrdn_field_reg
  import pwrdn_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               clr_light,
  output logic [FIELD_W-1:0] field_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= '0;
    end else if (wr_en) begin
      field_q         <= wr_data;
      field_q[B_RSVD] <= 1'b0;
    end else if (clr_light) begin
      field_q[B_LIGHT] <= 1'b0;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    field_q[B_RSVD] == 1'b0); // R2
endmodule

// File: rtl/pwrdn_entry_timer.sv
module pwrdn_entry_timer #(
  parameter int ENTRY_DELAY = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int CNT_W = (ENTRY_DELAY > 2) ? $clog2(ENTRY_DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_DELAY - 1);

  logic [CNT_W-1:0] cnt;

  assign done = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
    end else if (active && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R3
endmodule

// File: rtl/pwrdn_wake_qual.sv
module pwrdn_wake_qual #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wake_any,
  input  logic             wake_enabled,
  input  logic             gie,
  input  logic             nmie,
  output logic             wake,
  output logic             service
);
  logic any_line;
  logic en_line;

  assign any_line = |irq_lines;
  assign en_line  = |(irq_lines & irq_en);
  assign wake     = (wake_any && any_line) || (wake_enabled && en_line);
  assign service  = en_line && gie && nmie;
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int ENTRY_DELAY = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_we,
  input  logic [FIELD_W-1:0] csr_wdata,
  output logic [FIELD_W-1:0] csr_rdata,
  input  logic [N_IRQ-1:0]   irq_lines,
  input  logic [N_IRQ-1:0]   irq_en,
  input  logic               gie,
  input  logic               nmie,
  output logic               cpu_clk_en,
  output logic               periph_clk_en,
  output logic               resume,
  output logic               take_isr
);
  pd_state_t state, state_nx;
  logic      accept_wr, start_entry, entry_done;
  logic      wake, service, leave_light, deep_req;
  logic [FIELD_W-1:0] field_q;

  assign accept_wr   = csr_we && (state == ST_RUN);
  assign start_entry = accept_wr && (|csr_wdata[B_DEEP3:B_LIGHT]);
  assign leave_light = (state == ST_LIGHT) && wake;
  assign deep_req    = field_q[B_DEEP3] || field_q[B_DEEP2];
  assign csr_rdata   = field_q;

  pwrdn_field_reg i_field (
    .clk(clk), .rst(rst), .wr_en(accept_wr), .wr_data(csr_wdata),
    .clr_light(leave_light), .field_q(field_q)
  );

  pwrdn_entry_timer #(.ENTRY_DELAY(ENTRY_DELAY)) i_timer (
    .clk(clk), .rst(rst), .start(start_entry),
    .active(state == ST_ENTER), .done(entry_done)
  );

  pwrdn_wake_qual #(.N_IRQ(N_IRQ)) i_wake (
    .irq_lines(irq_lines), .irq_en(irq_en),
    .wake_any(field_q[B_WAKEANY]), .wake_enabled(field_q[B_WAKEEN]),
    .gie(gie), .nmie(nmie), .wake(wake), .service(service)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:   if (start_entry) state_nx = ST_ENTER;
      ST_ENTER: if (entry_done)  state_nx = deep_req ? ST_DEEP : ST_LIGHT;
      ST_LIGHT: if (wake)        state_nx = ST_RUN;
      ST_DEEP:                   state_nx = ST_DEEP;
      default:                   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_RUN;
      cpu_clk_en    <= 1'b1;
      periph_clk_en <= 1'b1;
      resume        <= 1'b0;
      take_isr      <= 1'b0;
    end else begin
      state         <= state_nx;
      cpu_clk_en    <= (state_nx == ST_RUN) || (state_nx == ST_ENTER);
      periph_clk_en <= (state_nx != ST_DEEP);
      resume        <= leave_light;
      take_isr      <= leave_light && service;
    end
  end

  AST_DEEP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEEP) |=> (state == ST_DEEP)); // R6
  AST_PERIPH_DEEP_ONLY: assert property (@(posedge clk) disable iff (rst)
    !periph_clk_en |-> !cpu_clk_en); // R7
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume); // R8
  AST_RESUME_FROM_LIGHT: assert property (@(posedge clk) disable iff (rst)
    $rose(resume) |-> ($past(state) == ST_LIGHT)); // R8
  AST_ISR_NEEDS_RESUME: assert property (@(posedge clk) disable iff (rst)
    take_isr |-> resume); // R10
  AST_ENTRY_FIELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ENTER) |=> $stable(csr_rdata)); // R5
endmodule

// File: tb/test_pwrdn_ctrl.sv
module test_pwrdn_ctrl;
  localparam int N_IRQ = 4;
  localparam int DLY   = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csr_we = 1'b0;
  logic [5:0] csr_wdata = '0;
  logic [5:0] csr_rdata;
  logic [3:0] irq_lines = '0;
  logic [3:0] irq_en = '0;
  logic       gie = 1'b0, nmie = 1'b0;
  logic       cpu_clk_en, periph_clk_en, resume, take_isr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwrdn_ctrl #(.N_IRQ(N_IRQ), .ENTRY_DELAY(DLY)) i_pwrdn_ctrl (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .irq_lines(irq_lines), .irq_en(irq_en),
    .gie(gie), .nmie(nmie), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .resume(resume), .take_isr(take_isr)
  );

  // {wdata[6], irq[4], ien[4], gie, nmie, exp_periph, exp_resume, exp_isr}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {6'b010001, 4'b0001, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 any line
    {6'b010001, 4'b0010, 4'b0010, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R10 isr
    {6'b010001, 4'b0010, 4'b0010, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R10 gie low
    {6'b010001, 4'b0010, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R10 nmie low
    {6'b001001, 4'b0100, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 not enabled
    {6'b001001, 4'b0100, 4'b0100, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R9 enabled
    {6'b000001, 4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 no wake bit
    {6'b010010, 4'b1111, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 deep2
    {6'b110111, 4'b1111, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 all bits
    {6'b011011, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R4 deep2 over light
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; csr_we = 1'b0; irq_lines = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_field(input logic [5:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 rdata", {2'b0, csr_rdata}, 8'h00);
    chk("R1 clk enables", {6'b0, cpu_clk_en, periph_clk_en}, 8'h03);
    chk("R1 resume/isr", {6'b0, resume, take_isr}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      irq_en = VEC[v][8:5]; gie = VEC[v][4]; nmie = VEC[v][3];
      @(negedge clk);
      csr_we = 1'b1; csr_wdata = VEC[v][18:13];
      @(posedge clk);                 // write edge E0
      #1 csr_we = 1'b0;
      repeat (DLY - 1) @(posedge clk); // E8
      @(negedge clk);
      chk($sformatf("R3 v%0d cpu before entry", v), {7'b0, cpu_clk_en}, 8'h01);
      @(posedge clk);                 // E9
      @(negedge clk);
      chk($sformatf("R3 v%0d cpu at entry", v), {7'b0, cpu_clk_en}, 8'h00);
      chk($sformatf("R7 v%0d periph", v), {7'b0, periph_clk_en}, {7'b0, VEC[v][2]});
      irq_lines = VEC[v][12:9];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R8 v%0d resume", v), {7'b0, resume}, {7'b0, VEC[v][1]});
      chk($sformatf("R10 v%0d take_isr", v), {7'b0, take_isr}, {7'b0, VEC[v][0]});
      irq_lines = '0;
      if (VEC[v][1]) begin
        chk($sformatf("R11 v%0d field after wake", v), {2'b0, csr_rdata},
            {2'b0, VEC[v][18:13] & 6'b011110});
        chk($sformatf("R8 v%0d cpu restored", v), {7'b0, cpu_clk_en}, 8'h01);
        @(negedge clk);
        chk($sformatf("R8 v%0d resume single", v), {7'b0, resume}, 8'h00);
      end else begin
        repeat (3) @(negedge clk);
        chk($sformatf("R6 v%0d still asleep", v), {7'b0, cpu_clk_en}, 8'h00);
      end
    end

    // R2 / R4: write with no level bits, reserved bit masked
    do_reset();
    write_field(6'b111000);
    chk("R2 reserved masked", {2'b0, csr_rdata}, 8'h18);
    repeat (DLY + 3) @(negedge clk);
    chk("R4 no level stays running", {6'b0, cpu_clk_en, periph_clk_en}, 8'h03);

    // R5: write during entry delay ignored
    do_reset();
    write_field(6'b010001);
    repeat (2) @(negedge clk);
    csr_we = 1'b1; csr_wdata = 6'b000100;
    @(negedge clk);
    csr_we = 1'b0;
    chk("R5 field unchanged", {2'b0, csr_rdata}, 8'h11);
    repeat (DLY) @(negedge clk);
    chk("R5 light level kept", {6'b0, cpu_clk_en, periph_clk_en}, 8'h01);

    // R6: deep level left only by reset
    do_reset();
    write_field(6'b010100);
    repeat (DLY + 2) @(negedge clk);
    irq_lines = 4'hF; irq_en = 4'hF;
    repeat (4) @(negedge clk);
    chk("R6 deep ignores irq", {5'b0, cpu_clk_en, periph_clk_en, resume}, 8'h00);
    irq_lines = '0;
    do_reset();
    chk("R6 reset exits deep", {6'b0, cpu_clk_en, periph_clk_en}, 8'h03);
    chk("R1 field after reset", {2'b0, csr_rdata}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule